// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block carries data across an 18-bit boundary in two directions, A to B and B to A. Each direction has its own storage per bit. Each bit acts as a transparent latch while its latch-enable is high. While the latch-enable is low, the bit becomes an edge-triggered register that loads on a rising bus-clock edge, and it holds its value when that bus clock sits at a steady level. Each side's output is presented as a data value plus a drive-enable flag per group. A synthesizable wrapper can turn that pair into tri-state pads. The design carries no inout nets.

The 18 bits form two 9-bit groups. Each group has its own output-enable, latch-enable and bus clock in each direction. Tying the two groups' controls together gives a single 18-bit transceiver. A test-mode input replaces the normal outputs with values supplied by test logic and freezes both storage arrays.

Every control and the bus clocks are sampled on a free-running system clock `clk`. A change on an input reaches the outputs one system-clock cycle later, including in transparent mode. Bus-clock edges are found by comparing each sample with the previous one.

Top module: `ubt_xcvr`

## Requirements
- R1: When a group's latch-enable is high and test mode is off, that group's output value equals the opposite side's input as sampled at the previous system-clock edge, and it follows every change.
- R2: When a group's latch-enable is low and its bus clock keeps the same level at two successive samples, the group's stored value does not change, whatever its input does.
- R3: When a group's latch-enable is low and its bus clock is sampled high after having been sampled low, the group stores the input present at that sample. A high-to-low transition stores nothing.
- R4: A group's drive-enable is 1 one system clock after its active-low output-enable is sampled 0, and 0 one system clock after it is sampled 1.
- R5: The A-to-B direction (inputs `a_in`, `ab_*`; outputs `b_out`, `b_drv`) and the B-to-A direction (inputs `b_in`, `ba_*`; outputs `a_out`, `a_drv`) do not affect each other.
- R6: Control index g of every control vector governs data bits [9g+8:9g] only. Group 0 is bits 8..0 and group 1 is bits 17..9. The groups operate independently.
- R7: While `test_mode` is 1, each output value equals the matching test value at once. Each drive-enable equals the matching test enable one system clock after it is sampled.
- R8: While `test_mode` is 1, neither storage array changes. After test mode ends, the values stored before test mode reappear.
- R9: While `rst_n` is 0, both storage arrays read zero and all drive-enables are 0, regardless of the output-enables.
- R10: No input change reaches an output value in the same system-clock cycle. The latency through the storage is exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 18 | A-side data arriving at the block |
| b_in | input | 18 | B-side data arriving at the block |
| ab_oe_n | input | 2 | Active-low B-side output-enable, one per group |
| ab_le | input | 2 | A-to-B latch-enable per group (1 = transparent) |
| ab_clk | input | 2 | A-to-B bus clock per group |
| ba_oe_n | input | 2 | Active-low A-side output-enable, one per group |
| ba_le | input | 2 | B-to-A latch-enable per group |
| ba_clk | input | 2 | B-to-A bus clock per group |
| test_mode | input | 1 | 1 = test logic owns the outputs and storage is frozen |
| test_a_val | input | 18 | A-side value driven in test mode |
| test_a_en | input | 2 | A-side drive-enable per group in test mode |
| test_b_val | input | 18 | B-side value driven in test mode |
| test_b_en | input | 2 | B-side drive-enable per group in test mode |
| a_out | output | 18 | Value presented to the A side |
| a_drv | output | 2 | A-side drive-enable per group |
| b_out | output | 18 | Value presented to the B side |
| b_drv | output | 2 | B-side drive-enable per group |

## Verification
The transparent case drives a new input every cycle. Matching output proves the latch path, and a check taken before the next edge shows the one-cycle latency. The register case holds the bus clock high while the input changes, then pulls it low with fresh data, and then raises it again. This sequence separates rising-edge capture from level capture and from falling-edge capture. Split control patterns (one group transparent and the other holding, or one clocked and the other idle) show whether a control leaks into the wrong group or direction. Entering and leaving test mode with different data on the inputs shows whether storage kept its value underneath the override.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  localparam int unsigned GRP_W_DEF   = 9;
  localparam int unsigned NUM_GRP_DEF = 2;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_EDGE = 2'd2
  } store_mode_e;

  // Storage mode from latch level, detected clock edge and freeze request.
  function automatic store_mode_e pick_mode(input logic le, input logic rise,
                                            input logic frozen);
    store_mode_e m;
    if (frozen)    m = MODE_HOLD;
    else if (le)   m = MODE_PASS;
    else if (rise) m = MODE_EDGE;
    else           m = MODE_HOLD;
    return m;
  endfunction

  // Low-to-high detection from the current and previous samples.
  function automatic logic edge_up(input logic now_s, input logic prev_s);
    return now_s & ~prev_s;
  endfunction

endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] rise
);
  import ubt_pkg::*;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = edge_up(sig_in[i], prev_q[i]);

    // R3: an edge is reported for one sample only while the level stays
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && sig_in[i]) |=> (!rise[i] || !$stable(sig_in[i])) || !sig_in[i]);
  end

endmodule

// File: rtl/ubt_store_cell.sv
module ubt_store_cell #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         rise,
  input  logic         frozen,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import ubt_pkg::*;

  store_mode_e mode_w;
  logic [W-1:0] q_r;

  assign mode_w = pick_mode(le, rise, frozen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      case (mode_w)
        MODE_PASS: q_r <= d;
        MODE_EDGE: q_r <= d;
        default:   q_r <= q_r;
      endcase
    end
  end

  assign q = q_r;

  // R1: transparent level loads every sampled input
  p_pass_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !frozen) |=> (q == $past(d)));

  // R2: latch low and no clock edge keeps the content
  p_hold_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !rise && !frozen) |=> $stable(q));

  // R3: a detected rising edge loads the sampled input
  p_edge_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && rise && !frozen) |=> (q == $past(d)));

  // R8: a freeze keeps the content
  p_frozen_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(q));

endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path #(
  parameter int unsigned GRP_W   = 9,
  parameter int unsigned NUM_GRP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GRP_W*NUM_GRP-1:0] d,
  input  logic [NUM_GRP-1:0]       oe_n,
  input  logic [NUM_GRP-1:0]       le,
  input  logic [NUM_GRP-1:0]       bclk,
  input  logic                     test_mode,
  input  logic [GRP_W*NUM_GRP-1:0] test_val,
  input  logic [NUM_GRP-1:0]       test_en,
  output logic [GRP_W*NUM_GRP-1:0] dout,
  output logic [NUM_GRP-1:0]       drv
);
  localparam int unsigned W = GRP_W * NUM_GRP;

  logic [NUM_GRP-1:0] bclk_rise;
  logic [W-1:0]       stored;
  logic [NUM_GRP-1:0] drv_q;

  ubt_edge_det #(.N(NUM_GRP)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (bclk),
    .rise   (bclk_rise)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    ubt_store_cell #(.W(GRP_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .le     (le[g]),
      .rise   (bclk_rise[g]),
      .frozen (test_mode),
      .d      (d[g*GRP_W +: GRP_W]),
      .q      (stored[g*GRP_W +: GRP_W])
    );

    // R4: output-enable low turns the drive on one cycle later
    p_oe_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !oe_n[g]) |=> drv[g]);

    // R4: output-enable high turns the drive off one cycle later
    p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && oe_n[g]) |=> !drv[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         drv_q <= '0;
    else if (test_mode) drv_q <= test_en;
    else                drv_q <= ~oe_n;
  end

  assign dout = test_mode ? test_val : stored;
  assign drv  = drv_q;

  // R7: the test enables reach the drive flags one cycle later
  p_test_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (drv == $past(test_en)));

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int unsigned GRP_W   = ubt_pkg::GRP_W_DEF,
  parameter int unsigned NUM_GRP = ubt_pkg::NUM_GRP_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GRP_W*NUM_GRP-1:0] a_in,
  input  logic [GRP_W*NUM_GRP-1:0] b_in,
  input  logic [NUM_GRP-1:0]       ab_oe_n,
  input  logic [NUM_GRP-1:0]       ab_le,
  input  logic [NUM_GRP-1:0]       ab_clk,
  input  logic [NUM_GRP-1:0]       ba_oe_n,
  input  logic [NUM_GRP-1:0]       ba_le,
  input  logic [NUM_GRP-1:0]       ba_clk,
  input  logic                     test_mode,
  input  logic [GRP_W*NUM_GRP-1:0] test_a_val,
  input  logic [NUM_GRP-1:0]       test_a_en,
  input  logic [GRP_W*NUM_GRP-1:0] test_b_val,
  input  logic [NUM_GRP-1:0]       test_b_en,
  output logic [GRP_W*NUM_GRP-1:0] a_out,
  output logic [NUM_GRP-1:0]       a_drv,
  output logic [GRP_W*NUM_GRP-1:0] b_out,
  output logic [NUM_GRP-1:0]       b_drv
);

  // R5: the two directions share only clock, reset and test mode
  ubt_dir_path #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_ab (
    .clk       (clk),
    .rst_n     (rst_n),
    .d         (a_in),
    .oe_n      (ab_oe_n),
    .le        (ab_le),
    .bclk      (ab_clk),
    .test_mode (test_mode),
    .test_val  (test_b_val),
    .test_en   (test_b_en),
    .dout      (b_out),
    .drv       (b_drv)
  );

  ubt_dir_path #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_ba (
    .clk       (clk),
    .rst_n     (rst_n),
    .d         (b_in),
    .oe_n      (ba_oe_n),
    .le        (ba_le),
    .bclk      (ba_clk),
    .test_mode (test_mode),
    .test_val  (test_a_val),
    .test_en   (test_a_en),
    .dout      (a_out),
    .drv       (a_drv)
  );

endmodule

// File: tb/ubt_xcvr_bench.sv
module ubt_xcvr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] a_in, b_in, test_a_val, test_b_val;
  logic [1:0]  ab_oe_n, ab_le, ab_clk, ba_oe_n, ba_le, ba_clk;
  logic [1:0]  test_a_en, test_b_en;
  logic        test_mode;
  logic [17:0] a_out, b_out;
  logic [1:0]  a_drv, b_drv;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ubt_xcvr u_ubt_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .test_mode(test_mode), .test_a_val(test_a_val), .test_a_en(test_a_en),
    .test_b_val(test_b_val), .test_b_en(test_b_en),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; a_in = 18'h3FFFF; b_in = 18'h2AAAA;
    ab_oe_n = 2'b00; ba_oe_n = 2'b00; ab_le = 2'b11; ba_le = 2'b11;
    ab_clk = 2'b00; ba_clk = 2'b00; test_mode = 1'b0;
    test_a_val = '0; test_b_val = '0; test_a_en = '0; test_b_en = '0;
    repeat (3) tick();
    chk("R9 b_out", b_out, 18'h0);
    chk("R9 a_out", a_out, 18'h0);
    chk("R9 b_drv", {16'h0, b_drv}, 18'h0);
    chk("R9 a_drv", {16'h0, a_drv}, 18'h0);
    ba_le = 2'b00; a_in = 18'h0; b_in = 18'h0;
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_pass();
    ab_le = 2'b11; a_in = 18'h12345;
    tick();
    chk("R1 pass first", b_out, 18'h12345);
    a_in = 18'h0ABCD;
    #1 chk("R10 no same-cycle change", b_out, 18'h12345);
    tick();
    chk("R1 pass follows", b_out, 18'h0ABCD);
  endtask

  task automatic t_hold();
    ab_le = 2'b00; a_in = 18'h3C3C3;
    tick();
    chk("R2 hold after le low", b_out, 18'h0ABCD);
    a_in = 18'h11111;
    repeat (2) tick();
    chk("R2 hold steady clock", b_out, 18'h0ABCD);
  endtask

  task automatic t_edge();
    a_in = 18'h22222; ab_clk = 2'b11;
    tick();
    chk("R3 rising capture", b_out, 18'h22222);
    a_in = 18'h33333;
    tick();
    chk("R3 clock held high", b_out, 18'h22222);
    a_in = 18'h04444; ab_clk = 2'b00;
    tick();
    chk("R3 falling ignored", b_out, 18'h22222);
    ab_clk = 2'b11;
    tick();
    chk("R3 second rising", b_out, 18'h04444);
  endtask

  task automatic t_oe();
    ab_oe_n = 2'b11;
    tick();
    chk("R4 drive off", {16'h0, b_drv}, 18'h0);
    ab_oe_n = 2'b00;
    #1 chk("R4 not yet on", {16'h0, b_drv}, 18'h0);
    tick();
    chk("R4 drive on", {16'h0, b_drv}, 18'h3);
    ab_oe_n = 2'b10;
    tick();
    chk("R4 R6 per-group drive", {16'h0, b_drv}, 18'h1);
  endtask

  task automatic t_dir();
    ba_le = 2'b11; b_in = 18'h15555; ba_oe_n = 2'b11;
    a_in = 18'h3FFFF;
    tick();
    chk("R5 a_out from b_in", a_out, 18'h15555);
    chk("R5 b_out untouched", b_out, 18'h04444);
    chk("R5 a_drv independent", {16'h0, a_drv}, 18'h0);
    ab_le = 2'b11; a_in = 18'h06060; ba_le = 2'b00; b_in = 18'h00F0F;
    tick();
    chk("R5 b_out updates", b_out, 18'h06060);
    chk("R5 a_out held", a_out, 18'h15555);
  endtask

  task automatic t_groups();
    ab_le = 2'b01; a_in = 18'h3FFFF;
    tick();
    chk("R6 only group0 passes", b_out, {9'h030, 9'h1FF});
    ab_le = 2'b00; ab_clk = 2'b00;
    tick();
    a_in = 18'h00000; ab_clk = 2'b10;
    tick();
    chk("R6 only group1 clocked", b_out, {9'h000, 9'h1FF});
  endtask

  task automatic t_test();
    test_mode = 1'b1; test_b_val = 18'h2D2D2; test_b_en = 2'b01;
    test_a_val = 18'h1B1B1; test_a_en = 2'b10;
    ab_le = 2'b11; ba_le = 2'b11; a_in = 18'h39393; b_in = 18'h27272;
    #1 chk("R7 value override immediate", b_out, 18'h2D2D2);
    tick();
    chk("R7 b_out test value", b_out, 18'h2D2D2);
    chk("R7 a_out test value", a_out, 18'h1B1B1);
    chk("R7 b_drv test enable", {16'h0, b_drv}, 18'h1);
    chk("R7 a_drv test enable", {16'h0, a_drv}, 18'h2);
    tick();
    test_mode = 1'b0; ab_le = 2'b00; ba_le = 2'b00;
    tick();
    chk("R8 b storage kept", b_out, {9'h000, 9'h1FF});
    chk("R8 a storage kept", a_out, 18'h15555);
    chk("R4 drive back to oe", {16'h0, b_drv}, 18'h1);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_hold();
    t_edge();
    t_oe();
    t_dir();
    t_groups();
    t_test();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule